// File: doc/BRIEF.md
# Accumulator Flag Operation Unit

This unit holds an 8-bit accumulator, an 8-bit flag register and a shadow copy of the accumulator/flag pair. It runs four single-byte instructions that touch only these registers: invert the accumulator, force the carry, toggle the carry, and swap the live pair with the shadow pair. An instruction is selected on `op_sel` and takes effect on the rising clock edge where `op_valid` is high. The current accumulator and flags are always visible on the outputs.

The two undocumented flag bits (bit 5 and bit 3) are not left stale. After every invert, force-carry or toggle-carry they are reloaded from the accumulator. The toggle-carry instruction also copies the previous carry into the half-carry bit. A synchronous reset loads the same value into all four registers. That value is `RESET_VAL`, which is 0x00 by default and can be set to 0xFF.

Top module: `acc_flag_unit`

## Requirements
- R1: Flag bit positions are fixed: sign 7, zero 6, undocumented 5, half-carry 4, undocumented 3, parity/overflow 2, subtract 1, carry 0. Operation codes on `op_sel` are 0 = invert accumulator, 1 = force carry, 2 = toggle carry, 3 = swap with shadow.
- R2: Invert accumulator (code 0) writes the bitwise complement of A into A. It sets half-carry and subtract, and leaves sign, zero, parity/overflow and carry unchanged.
- R3: Force carry (code 1) sets carry and clears half-carry and subtract. It keeps sign, zero and parity/overflow, and does not change A.
- R4: Toggle carry (code 2) loads half-carry with the old carry, inverts carry and clears subtract. It keeps sign, zero and parity/overflow, and does not change A.
- R5: Swap (code 3) exchanges A with the shadow accumulator and F with the shadow flags in one edge. Two swaps in a row restore the original pair.
- R6: While `op_valid` is low, A, F and the shadow pair keep their values whatever `op_sel` holds.
- R7: When `rst` is high at a clock edge, A, F, the shadow accumulator and the shadow flags all become `RESET_VAL`.
- R8: After codes 0, 1 and 2, flag bits 5 and 3 equal bits 5 and 3 of the accumulator value that results from the instruction.
- R9: Outputs do not change before the clock edge that samples `op_valid` high. The new values are visible right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Execute the selected operation on this edge |
| op_sel | input | 2 | Operation code (see R1) |
| acc_out | output | 8 | Current accumulator |
| flag_out | output | 8 | Current flag register |

## Verification
The shadow pair has no port of its own, so a wrong shadow value stays hidden until the next swap. The bench therefore issues swaps after reset, after flag operations and in back-to-back pairs, so that a corrupted shadow appears on `acc_out`/`flag_out` within one cycle of the swap. A wrong carry or half-carry appears one cycle after the operation. Chained toggle-carry operations expose a wrong carry history on the very next edge. A second instance with an all-ones reset value makes the kept sign/zero/parity bits observable.

// File: rtl/acc_flag_unit.sv
module acc_flag_unit #(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       op_valid,
  input  logic [1:0] op_sel,
  output logic [7:0] acc_out,
  output logic [7:0] flag_out
);
  localparam int C_BIT  = 0;
  localparam int N_BIT  = 1;
  localparam int PV_BIT = 2;
  localparam int X3_BIT = 3;
  localparam int H_BIT  = 4;
  localparam int X5_BIT = 5;
  localparam int Z_BIT  = 6;
  localparam int S_BIT  = 7;

  localparam logic [7:0] C_M     = 8'(1) << C_BIT;
  localparam logic [7:0] N_M     = 8'(1) << N_BIT;
  localparam logic [7:0] H_M     = 8'(1) << H_BIT;
  localparam logic [7:0] UNDOC_M = (8'(1) << X3_BIT) | (8'(1) << X5_BIT);
  localparam logic [7:0] KEEP_M  = (8'(1) << S_BIT) | (8'(1) << Z_BIT) | (8'(1) << PV_BIT);

  localparam logic [1:0] OP_CPL = 2'd0;
  localparam logic [1:0] OP_SCF = 2'd1;
  localparam logic [1:0] OP_CCF = 2'd2;
  localparam logic [1:0] OP_XCH = 2'd3;

  logic [7:0] acc_q, flg_q, acc_sh_q, flg_sh_q;
  logic [7:0] acc_d, flg_d, acc_sh_d, flg_sh_d;
  logic [7:0] cpl_acc, cpl_flg, scf_flg, ccf_flg;
  logic       old_c;

  assign old_c   = flg_q[C_BIT];
  assign cpl_acc = ~acc_q;
  assign cpl_flg = (flg_q & (KEEP_M | C_M)) | H_M | N_M | (cpl_acc & UNDOC_M);
  assign scf_flg = (flg_q & KEEP_M) | C_M | (acc_q & UNDOC_M);
  assign ccf_flg = (flg_q & KEEP_M) | (old_c ? H_M : 8'h00) | (old_c ? 8'h00 : C_M)
                 | (acc_q & UNDOC_M);

  always_comb begin
    acc_d    = acc_q;
    flg_d    = flg_q;
    acc_sh_d = acc_sh_q;
    flg_sh_d = flg_sh_q;
    if (op_valid) begin
      unique case (op_sel)
        OP_CPL: begin acc_d = cpl_acc; flg_d = cpl_flg; end
        OP_SCF: flg_d = scf_flg;
        OP_CCF: flg_d = ccf_flg;
        OP_XCH: begin
          acc_d    = acc_sh_q;
          flg_d    = flg_sh_q;
          acc_sh_d = acc_q;
          flg_sh_d = flg_q;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q    <= RESET_VAL;
      flg_q    <= RESET_VAL;
      acc_sh_q <= RESET_VAL;
      flg_sh_q <= RESET_VAL;
    end else begin
      acc_q    <= acc_d;
      flg_q    <= flg_d;
      acc_sh_q <= acc_sh_d;
      flg_sh_q <= flg_sh_d;
    end
  end

  assign acc_out  = acc_q;
  assign flag_out = flg_q;

  assert_reset_load_R7: assert property (@(posedge clk)
    rst |=> (acc_out == RESET_VAL && flag_out == RESET_VAL &&
             acc_sh_q == RESET_VAL && flg_sh_q == RESET_VAL));

  assert_cpl_result_R2: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CPL) |=>
      (acc_out == ~$past(acc_out) && flag_out[H_BIT] && flag_out[N_BIT] &&
       (flag_out & (KEEP_M | C_M)) == ($past(flag_out) & (KEEP_M | C_M))));

  assert_scf_result_R3: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_SCF) |=>
      (flag_out[C_BIT] && !flag_out[H_BIT] && !flag_out[N_BIT] && $stable(acc_out)));

  assert_ccf_result_R4: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_CCF) |=>
      (flag_out[H_BIT] == $past(flag_out[C_BIT]) &&
       flag_out[C_BIT] != $past(flag_out[C_BIT]) && !flag_out[N_BIT]));

  assert_swap_pair_R5: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel == OP_XCH) |=>
      (acc_out == $past(acc_sh_q) && flag_out == $past(flg_sh_q) &&
       acc_sh_q == $past(acc_out) && flg_sh_q == $past(flag_out)));

  assert_idle_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> ($stable(acc_out) && $stable(flag_out) &&
                   $stable(acc_sh_q) && $stable(flg_sh_q)));

  assert_undoc_track_R8: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_sel != OP_XCH) |=>
      (flag_out[X5_BIT] == acc_out[X5_BIT] && flag_out[X3_BIT] == acc_out[X3_BIT]));
endmodule

// File: tb/acc_flag_unit_tb.sv
module acc_flag_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [1:0] op_sel = 2'd0;
  logic [7:0] acc0, flg0, acc1, flg1;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  acc_flag_unit #(.RESET_VAL(8'h00)) dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_out(acc0), .flag_out(flg0));

  acc_flag_unit #(.RESET_VAL(8'hFF)) dut_ff (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
    .acc_out(acc1), .flag_out(flg1));

  typedef struct {
    logic [7:0] a0, f0, a1, f1;
    string      req;
  } exp_t;

  exp_t sb_q[$];

  logic [7:0] ma[2], mf[2], msa[2], msf[2];

  task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
    end
  endtask

  task automatic model_step(bit r, bit v, logic [1:0] s);
    for (int i = 0; i < 2; i++) begin
      logic [7:0] t;
      if (r) begin
        t = (i == 0) ? 8'h00 : 8'hFF;
        ma[i] = t; mf[i] = t; msa[i] = t; msf[i] = t;
      end else if (v) begin
        case (s)
          2'd0: begin
            ma[i] = ~ma[i];
            mf[i] = (mf[i] & 8'hC5) | 8'h12 | (ma[i] & 8'h28);
          end
          2'd1: mf[i] = (mf[i] & 8'hC4) | 8'h01 | (ma[i] & 8'h28);
          2'd2: mf[i] = (mf[i] & 8'hC4) | (mf[i][0] ? 8'h10 : 8'h01) | (ma[i] & 8'h28);
          default: begin
            t = ma[i]; ma[i] = msa[i]; msa[i] = t;
            t = mf[i]; mf[i] = msf[i]; msf[i] = t;
          end
        endcase
      end
    end
  endtask

  task automatic drive(bit r, bit v, logic [1:0] s, string req);
    exp_t e;
    @(negedge clk);
    rst = r; op_valid = v; op_sel = s;
    #1;
    if (!r) begin
      check8("R9", "acc before edge", acc0, ma[0]);
      check8("R9", "flags before edge", flg0, mf[0]);
    end
    @(posedge clk);
    model_step(r, v, s);
    e.a0 = ma[0]; e.f0 = mf[0]; e.a1 = ma[1]; e.f1 = mf[1]; e.req = req;
    #1 sb_q.push_back(e);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        check8(e.req, "acc (reset 00)", acc0, e.a0);
        check8(e.req, "flags (reset 00)", flg0, e.f0);
        check8(e.req, "acc (reset FF)", acc1, e.a1);
        check8(e.req, "flags (reset FF)", flg1, e.f1);
      end
    end
  end

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : stimulus
    for (int i = 0; i < 2; i++) begin ma[i] = 'x; mf[i] = 'x; msa[i] = 'x; msf[i] = 'x; end
    drive(1, 0, 2'd0, "R7 reset");
    drive(0, 1, 2'd0, "R2 R8 invert");
    drive(0, 1, 2'd1, "R3 R8 force carry");
    drive(0, 1, 2'd2, "R4 R8 toggle carry from 1");
    drive(0, 1, 2'd2, "R4 toggle carry from 0");
    drive(0, 1, 2'd3, "R5 swap with reset shadow");
    drive(0, 1, 2'd0, "R2 invert after swap");
    drive(0, 1, 2'd1, "R3 force carry");
    drive(0, 0, 2'd0, "R6 idle code 0");
    drive(0, 0, 2'd3, "R6 idle code 3");
    drive(0, 0, 2'd2, "R6 idle code 2");
    drive(0, 1, 2'd3, "R5 swap back");
    drive(0, 1, 2'd3, "R5 swap again");
    drive(0, 1, 2'd2, "R4 toggle carry");
    drive(0, 1, 2'd0, "R2 R1 invert");
    drive(0, 1, 2'd2, "R4 R8 toggle carry");
    drive(0, 1, 2'd1, "R3 R1 force carry");
    drive(1, 1, 2'd0, "R7 reset overrides op");
    drive(0, 1, 2'd3, "R7 R5 shadow reset");
    drive(0, 1, 2'd0, "R2 invert");
    drive(0, 1, 2'd3, "R5 swap");
    drive(0, 0, 2'd1, "R6 idle");
    while (sb_q.size() > 0) @(negedge clk);
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule